// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit line of a CAN protocol controller and the enable of the bus driver. Its job is to stop a faulty node from holding the bus dominant forever. It synchronizes the transmit input, watches for each change from recessive to dominant, and times how long the input then stays dominant. If the input is still dominant when the programmed number of clock cycles has passed, the block withdraws the drive command and raises a fault flag. The fault holds, and the driver stays off, until the input goes back to recessive.

The guard works only while the normal-mode qualifier is high, because that is the only mode in which the driver runs. When the qualifier drops, the drive command is withdrawn at once, the timer is reset and the fault is cleared. The receive path is separate from this block and keeps following the bus while a fault is present. The timeout length is given in clock cycles. A counter width derived from it lets the limit cover a window of 1.2 ms to 4.0 ms at any practical clock rate.

Top module: `txd_timeout_guard`

## Requirements
- R1: After a synchronous reset, `drv_dom` is 0 and `dto_fault` is 0.
- R2: Input polarity: `tx_in`=0 means dominant and `tx_in`=1 means recessive. `drv_dom`=1 commands the driver to drive dominant. `tx_in` passes through a two-flop synchronizer, so `drv_dom` rises at the second rising clock edge after `tx_in` falls.
- R3: A dominant stretch of fewer than TIMEOUT_CYC clock edges reaches `drv_dom` with its length unchanged and does not raise `dto_fault`.
- R4: A dominant stretch of TIMEOUT_CYC clock edges or more gives exactly TIMEOUT_CYC cycles of `drv_dom`=1. On the edge where `drv_dom` is forced low, `dto_fault` rises.
- R5: While `dto_fault` is 1 and `tx_in` stays 0, `drv_dom` stays 0 however long the input is held. A held level never restarts the timer; only a falling edge arms it.
- R6: `dto_fault` clears at the third rising edge after `tx_in` returns to 1. The next dominant stretch is then driven normally.
- R7: When `normal_en`=0, `drv_dom` is 0 in the same cycle, with no register delay. `dto_fault` is 0 after the next rising edge and the timer is reset.
- R8: Entering normal mode while the synchronized input is already dominant counts as a falling edge. `drv_dom` is 1 for exactly TIMEOUT_CYC cycles, counted from the cycle `normal_en` rises, and then `dto_fault` rises.
- R9: TIMEOUT_CYC must be at least 2. The counter width is derived from TIMEOUT_CYC, so any count from 150000 to 500000 cycles (1.2 ms to 4.0 ms at 125 MHz) is legal, and the internal count never exceeds TIMEOUT_CYC-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_in | input | 1 | Transmit data from the controller (0 = dominant), asynchronous |
| normal_en | input | 1 | High while the transceiver is in normal mode |
| drv_dom | output | 1 | Gated command to drive the bus dominant |
| dto_fault | output | 1 | Dominant timeout fault flag |

## Verification
The bench builds the guard with TIMEOUT_CYC = 16 in place of the default 300000. With this value a timeout takes tens of cycles rather than hundreds of thousands. Stretches of one cycle below, exactly at and well above the limit all fit into one short run. So do a long hold while faulted, release timing, a mode drop in the middle of a stretch and mode re-entry with the input low. The same count width logic applies at the real millisecond-scale limits.

// File: rtl/txg_pkg.sv
// Shared definitions for the transmit dominant timeout guard.
// Assumes bus levels are coded low = dominant, high = recessive.
package txg_pkg;
    localparam logic LVL_REC = 1'b1;
    localparam logic LVL_DOM = 1'b0;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_TRIP = 2'd2
    } tmr_st_t;
endpackage

// File: rtl/txg_sync.sv
// Multi-stage synchronizer for the asynchronous transmit input.
// Assumes STAGES >= 2; resets to the recessive level so reset does not look like an edge.
module txg_sync
    import txg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the input through the stages; reset loads recessive.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= {STAGES{LVL_REC}};
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/txg_dto_timer.sv
// Dominant timer: a falling edge of the synchronized level arms it, and a return to
// recessive or leaving normal mode clears it. It trips after LIMIT dominant cycles.
// Assumes LIMIT >= 2. The edge register is held recessive outside normal mode, so
// entering normal mode with a dominant level counts as an edge.
module txg_dto_timer
    import txg_pkg::*;
#(
    parameter int unsigned LIMIT = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic normal_en,
    input  logic tx_lvl,
    output logic fault
);
    localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    tmr_st_t       st;
    logic          lvl_q;
    logic [CW-1:0] cnt;
    logic          fall;

    // Edge detect against the previous level.
    assign fall = lvl_q & (tx_lvl == LVL_DOM);

    // Timer state, count and edge register.
    always_ff @(posedge clk) begin
        if (!rst_n || !normal_en) begin
            st    <= TMR_IDLE;
            cnt   <= '0;
            lvl_q <= LVL_REC;
        end else begin
            lvl_q <= tx_lvl;
            if (tx_lvl == LVL_REC) begin
                st  <= TMR_IDLE;
                cnt <= '0;
            end else if (fall) begin
                st  <= TMR_RUN;
                cnt <= CW'(1);
            end else if (st == TMR_RUN) begin
                if (cnt == LAST) begin
                    st  <= TMR_TRIP;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign fault = (st == TMR_TRIP);

    assert_trip_needs_dom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(tx_lvl == LVL_DOM));
    assert_clear_on_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && tx_lvl == LVL_REC) |=> !fault);
    assert_mode_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_en |=> !fault);
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/txg_drive_gate.sv
// Combines the synchronized level, the mode and the fault into the driver command.
// Assumes the fault input is registered; the mode acts with no register delay.
module txg_drive_gate
    import txg_pkg::*;
(
    input  logic normal_en,
    input  logic tx_lvl,
    input  logic fault,
    output logic drv_dom
);
    // Drive dominant only in normal mode, on a dominant level, with no fault.
    always_comb begin
        drv_dom = normal_en && (tx_lvl == LVL_DOM) && !fault;
    end
endmodule

// File: rtl/txd_timeout_guard.sv
// Top of the transmit dominant timeout guard: synchronizer, edge-armed timer and
// output gate. TIMEOUT_CYC is the dominant limit in clock cycles (>= 2).
module txd_timeout_guard #(
    parameter int unsigned TIMEOUT_CYC = 300000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in,
    input  logic normal_en,
    output logic drv_dom,
    output logic dto_fault
);
    logic tx_lvl;

    txg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tx_in),
        .q     (tx_lvl)
    );

    txg_dto_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .normal_en (normal_en),
        .tx_lvl    (tx_lvl),
        .fault     (dto_fault)
    );

    txg_drive_gate u_gate (
        .normal_en (normal_en),
        .tx_lvl    (tx_lvl),
        .fault     (dto_fault),
        .drv_dom   (drv_dom)
    );

    assert_trip_cuts_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dto_fault) |-> $past(drv_dom));
    assert_drive_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom |-> normal_en);
    assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dto_fault && !tx_lvl) |=> !drv_dom);
endmodule

// File: tb/tb_txd_timeout_guard.sv
`timescale 1ns/1ps
module tb_txd_timeout_guard;
    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_in = 1'b1;
    logic normal_en = 1'b1;
    logic drv_dom, dto_fault;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    bit mon_on = 0;

    typedef struct { int len; int flt; string req; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    txd_timeout_guard #(.TIMEOUT_CYC(T)) dut (
        .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .normal_en(normal_en),
        .drv_dom(drv_dom), .dto_fault(dto_fault)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int len, int flt, string req);
        exp_t e;
        e.len = len; e.flt = flt; e.req = req;
        q.push_back(e);
    endtask

    // Driver: hold tx_in dominant for L edges, then idle recessive.
    task automatic burst(int L, string req);
        push((L < T) ? L : T, (L >= T) ? 1 : 0, req);
        @(negedge clk) tx_in = 1'b0;
        repeat (L) @(negedge clk);
        tx_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Monitor: measure each run of drv_dom and compare with the scoreboard queue.
    int run = 0;
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            if (drv_dom) run++;
            else if (run > 0) begin
                if (q.size() == 0) begin
                    chk("R5", "unexpected drive run length", run, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.req, "drive run length", run, e.len);
                    chk(e.req, "fault at run end", int'(dto_fault), e.flt);
                end
                run = 0;
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk("R1", "drv_dom in reset", int'(drv_dom), 0);
        chk("R1", "dto_fault in reset", int'(dto_fault), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "drv_dom after reset", int'(drv_dom), 0);
        chk("R1", "dto_fault after reset", int'(dto_fault), 0);
        mon_on = 1;

        // R2: latency of two edges, 3-cycle stretch
        push(3, 0, "R2");
        @(negedge clk) tx_in = 1'b0;
        @(negedge clk); #1 chk("R2", "drv_dom after first edge", int'(drv_dom), 0);
        @(negedge clk); #1 chk("R2", "drv_dom after second edge", int'(drv_dom), 1);
        @(negedge clk) tx_in = 1'b1;
        repeat (6) @(negedge clk);

        // R3 / R4: lengths around the limit
        burst(1, "R3");
        burst(T - 1, "R3");
        burst(T, "R4");
        burst(T + 10, "R4");

        // R5 / R6: long hold while faulted, then release timing
        push(T, 1, "R4");
        @(negedge clk) tx_in = 1'b0;
        repeat (T + 30) @(negedge clk);
        #1;
        chk("R5", "fault during long hold", int'(dto_fault), 1);
        chk("R5", "drv_dom during long hold", int'(drv_dom), 0);
        @(negedge clk) tx_in = 1'b1;
        @(negedge clk);
        @(negedge clk); #1 chk("R6", "fault two edges after release", int'(dto_fault), 1);
        @(negedge clk); #1 chk("R6", "fault three edges after release", int'(dto_fault), 0);
        repeat (3) @(negedge clk);
        burst(4, "R6");

        // R7: mode drop mid-stretch cuts the drive at once
        push(4, 0, "R7");
        @(negedge clk) tx_in = 1'b0;
        repeat (6) @(negedge clk);
        normal_en = 1'b0;
        #1 chk("R7", "drv_dom same cycle as mode drop", int'(drv_dom), 0);
        @(negedge clk) tx_in = 1'b1;
        repeat (3) @(negedge clk);
        normal_en = 1'b1;
        repeat (6) @(negedge clk);

        // R7 / R8: mode drop clears fault, re-entry with dominant level re-arms
        push(T, 1, "R4");
        @(negedge clk) tx_in = 1'b0;
        repeat (T + 10) @(negedge clk);
        normal_en = 1'b0;
        @(negedge clk); #1 chk("R7", "fault after mode drop", int'(dto_fault), 0);
        repeat (3) @(negedge clk);
        push(T, 1, "R8");
        normal_en = 1'b1;
        repeat (T + 10) @(negedge clk);
        #1 chk("R8", "fault after re-entry timeout", int'(dto_fault), 1);
        @(negedge clk) tx_in = 1'b1;
        repeat (8) @(negedge clk);

        chk("R5", "scoreboard items left", q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule